// File: doc/BRIEF.md
# Two-Dimensional Product Code Encoder

This block turns a square array of 25 x 25 information bits into a 31 x 31 product codeword for a block turbo code. Both axes use the same systematic expurgated BCH (31,25) component code. The overall rate is 625/961, about 0.65. Information bits arrive one per handshake in row-major order. Each row of 25 bits is extended with 6 parity bits while it is being loaded. After the last information bit, every one of the 31 columns is encoded into 6 parity rows, one column per clock. That includes the six row-parity columns, so the bottom-right 6 x 6 corner holds checks on checks.

The finished codeword leaves one bit per handshake, also row-major. A last flag marks the final bit. While a codeword is held or being sent, the input side is closed. It opens again once the final output bit has been taken. A synchronous active-high reset abandons any partial block and clears the stored array and the shift-register state.

Top module: `pc_product_encoder`

## Requirements
- R1: During reset and in the cycle after it, `in_ready` is 1 and `out_valid` is 0. After reset the block accepts information bits.
- R2: Information bit number i (counted from 0 in arrival order) appears as codeword bit (row i/25, column i%25). Codeword bits are indexed row*31+column in output order, for row and column below 25.
- R3: In rows 0..24, columns 25..30 hold the remainder of x^6·m(x) divided by g(x) = x^6+x^5+x^3+x^2+x+1. Here m(x) takes the row's column-0 bit as its x^24 coefficient. Column 25 carries the x^5 coefficient of the remainder and column 30 carries the x^0 coefficient.
- R4: For every column 0..30, rows 25..30 hold the same remainder as in R3, computed over that column's rows 0..24. Row 0 is the highest-degree message coefficient and row 25 is the x^5 coefficient. This covers the row-parity columns too.
- R5: The 961 codeword bits leave in row-major order with column 0 first. `out_last` is 1 on bit 960 only. After that bit is accepted, `in_ready` returns to 1.
- R6: `in_ready` and `out_valid` are never both 1. Input offered from the last accepted information bit until the final output bit is accepted is not taken, and it does not change the codeword.
- R7: While `out_valid` is 1 and `out_ready` is 0, on the next cycle `out_valid` stays 1 and `out_bit` and `out_last` keep their values.
- R8: A reset that arrives partway through loading discards the partial block. The next full block is encoded exactly as if it were the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Block can take an information bit |
| in_bit | input | 1 | Information bit value |
| out_valid | output | 1 | Codeword bit available |
| out_ready | input | 1 | Consumer takes the codeword bit |
| out_bit | output | 1 | Codeword bit value |
| out_last | output | 1 | Marks the final codeword bit |

## Verification
The encoder is driven with several blocks: all zeros, all ones, a single one at the first information position, a single one at the last information position, a checkerboard and pseudo-random fills. The all-zero block must give an all-zero codeword. The all-ones block exercises the odd-weight factor of the generator. The two single-one blocks expose any misplaced parity tap or a reversed bit order at either end of a row or column. The random blocks are sent under random output back-pressure, with the next block offered while the previous codeword is still streaming, so a premature accept or a lost hold shifts the whole stream. A reset in the middle of a row, followed by a fresh block, checks that no partial shift-register or array content survives.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam int N  = 31;
    localparam int K  = 25;
    localparam int P  = N - K;
    localparam int IW = $clog2(N);
    localparam int CW = $clog2(N * N);

    // Generator (x+1)(x^5+x^2+1) = x^6+x^5+x^3+x^2+x+1; leading term implied
    localparam logic [P-1:0] GEN_TAPS = 6'b101111;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_COLS,
        ST_SEND
    } pc_state_e;

    typedef struct packed {
        logic [IW-1:0] row;
        logic [IW-1:0] col;
    } pc_pos_t;

    function automatic logic [P-1:0] lfsr_step(input logic [P-1:0] r, input logic d);
        logic fb;
        fb = d ^ r[P-1];
        return {r[P-2:0], 1'b0} ^ (fb ? GEN_TAPS : '0);
    endfunction

    // msg[K-1] is the first (highest-degree) message bit
    function automatic logic [P-1:0] parity_of(input logic [K-1:0] msg);
        logic [P-1:0] r;
        r = '0;
        for (int i = K - 1; i >= 0; i--) begin
            r = lfsr_step(r, msg[i]);
        end
        return r;
    endfunction

endpackage

// File: rtl/pc_row_lfsr.sv
module pc_row_lfsr
    import pc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         din,
    input  logic         row_done,
    output logic [P-1:0] rem_next
);

    logic [P-1:0] rem_q;

    assign rem_next = lfsr_step(rem_q, din);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (step) begin
            rem_q <= row_done ? '0 : rem_next;
        end
    end

endmodule

// File: rtl/pc_col_parity.sv
module pc_col_parity
    import pc_pkg::*;
(
    input  logic [K-1:0] col_bits,
    output logic [P-1:0] parity
);

    assign parity = parity_of(col_bits);

endmodule

// File: rtl/pc_pos_counter.sv
module pc_pos_counter
    import pc_pkg::*;
#(
    parameter int NROW = K,
    parameter int NCOL = K
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    inc,
    output pc_pos_t pos,
    output logic    row_end,
    output logic    blk_end
);

    localparam logic [IW-1:0] LAST_ROW = IW'(NROW - 1);
    localparam logic [IW-1:0] LAST_COL = IW'(NCOL - 1);

    assign row_end = (pos.col == LAST_COL);
    assign blk_end = row_end && (pos.row == LAST_ROW);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (inc) begin
            if (blk_end) begin
                pos <= '0;
            end else if (row_end) begin
                pos.row <= pos.row + 1'b1;
                pos.col <= '0;
            end else begin
                pos.col <= pos.col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pc_product_encoder.sv
module pc_product_encoder
    import pc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    output logic out_valid,
    input  logic out_ready,
    output logic out_bit,
    output logic out_last
);

    localparam logic [IW-1:0] LAST_COL = IW'(N - 1);

    pc_state_e     state;
    logic [N-1:0]  arr [N];
    logic [IW-1:0] col_idx;

    logic          in_fire, out_fire;
    pc_pos_t       ld_pos, sd_pos;
    logic          ld_row_end, ld_blk_end;
    logic          sd_row_end, sd_blk_end;
    logic [P-1:0]  row_par;
    logic [K-1:0]  col_bits;
    logic [P-1:0]  col_par;

    assign in_ready  = (state == ST_LOAD);
    assign out_valid = (state == ST_SEND);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;

    pc_pos_counter #(.NROW(K), .NCOL(K)) u_load_pos (
        .clk     (clk),
        .rst     (rst),
        .inc     (in_fire),
        .pos     (ld_pos),
        .row_end (ld_row_end),
        .blk_end (ld_blk_end)
    );

    pc_pos_counter #(.NROW(N), .NCOL(N)) u_send_pos (
        .clk     (clk),
        .rst     (rst),
        .inc     (out_fire),
        .pos     (sd_pos),
        .row_end (sd_row_end),
        .blk_end (sd_blk_end)
    );

    pc_row_lfsr u_row_lfsr (
        .clk      (clk),
        .rst      (rst),
        .step     (in_fire),
        .din      (in_bit),
        .row_done (ld_row_end),
        .rem_next (row_par)
    );

    // Gather one stored column, row 0 as highest-degree coefficient
    for (genvar gi = 0; gi < K; gi++) begin : g_col_tap
        assign col_bits[K-1-gi] = arr[gi][col_idx];
    end

    pc_col_parity u_col_parity (
        .col_bits (col_bits),
        .parity   (col_par)
    );

    assign out_bit  = arr[sd_pos.row][sd_pos.col];
    assign out_last = out_valid && sd_blk_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_LOAD;
            col_idx <= '0;
            for (int r = 0; r < N; r++) begin
                arr[r] <= '0;
            end
        end else begin
            case (state)
                ST_LOAD: begin
                    if (in_fire) begin
                        arr[ld_pos.row][ld_pos.col] <= in_bit;
                        if (ld_row_end) begin
                            for (int j = 0; j < P; j++) begin
                                arr[ld_pos.row][K+j] <= row_par[P-1-j];
                            end
                        end
                        if (ld_blk_end) begin
                            state   <= ST_COLS;
                            col_idx <= '0;
                        end
                    end
                end
                ST_COLS: begin
                    for (int j = 0; j < P; j++) begin
                        arr[K+j][col_idx] <= col_par[P-1-j];
                    end
                    if (col_idx == LAST_COL) begin
                        state <= ST_SEND;
                    end else begin
                        col_idx <= col_idx + 1'b1;
                    end
                end
                ST_SEND: begin
                    if (out_fire && sd_blk_end) begin
                        state <= ST_LOAD;
                    end
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/pc_encoder_checks.sv
module pc_encoder_checks
    import pc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic in_bit,
    input logic out_valid,
    input logic out_ready,
    input logic out_bit,
    input logic out_last
);

    logic [CW-1:0] sent_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_cnt <= '0;
        end else if (out_valid && out_ready) begin
            sent_cnt <= out_last ? '0 : sent_cnt + 1'b1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    a_r5_last_position: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (sent_cnt == CW'(N * N - 1)));

    a_r5_reopen_input: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

endmodule

bind pc_product_encoder pc_encoder_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bit    (in_bit),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .out_last  (out_last)
);

// File: tb/tb_pc_product_encoder.sv
`timescale 1ns/1ps
module tb_pc_product_encoder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid, out_bit, out_last;

    always #2.5 clk = ~clk;

    pc_product_encoder dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    typedef struct {
        bit b;
        bit last;
        int region;
    } exp_t;

    exp_t q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    bit bp_on = 0;
    logic [15:0] bp_lfsr = 16'hACE1;
    int unsigned rng = 32'h1234_5678;

    function automatic string region_tag(int region);
        if (region == 2) return "R2";
        if (region == 3) return "R3";
        return "R4";
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Long division of x^6*m(x) by x^6+x^5+x^3+x^2+x+1; m[24] highest degree
    function automatic logic [5:0] ref_par(input logic [24:0] m);
        logic [30:0] w;
        w = {m, 6'b0};
        for (int d = 30; d >= 6; d--) begin
            if (w[d]) w = w ^ (31'b1101111 << (d - 6));
        end
        return w[5:0];
    endfunction

    function automatic int unsigned next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    task automatic push_block(input logic [624:0] info);
        bit cw [31][31];
        logic [24:0] m;
        logic [5:0] p;
        exp_t e;
        for (int r = 0; r < 25; r++) begin
            for (int c = 0; c < 25; c++) cw[r][c] = info[r*25+c];
            for (int c = 0; c < 25; c++) m[24-c] = cw[r][c];
            p = ref_par(m);
            for (int j = 0; j < 6; j++) cw[r][25+j] = p[5-j];
        end
        for (int c = 0; c < 31; c++) begin
            for (int r = 0; r < 25; r++) m[24-r] = cw[r][c];
            p = ref_par(m);
            for (int j = 0; j < 6; j++) cw[25+j][c] = p[5-j];
        end
        for (int r = 0; r < 31; r++) begin
            for (int c = 0; c < 31; c++) begin
                e.b = cw[r][c];
                e.last = (r == 30) && (c == 30);
                e.region = (r < 25 && c < 25) ? 2 : ((r < 25) ? 3 : 4);
                q.push_back(e);
            end
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        in_valid = 1'b1;
        in_bit = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic send_block(input logic [624:0] info);
        push_block(info);
        for (int i = 0; i < 625; i++) put_bit(info[i]);
    endtask

    task automatic wait_drained();
        @(negedge clk);
        in_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        #1;
        check(in_ready === 1'b1 && out_valid === 1'b0, "R5", "input reopens after last bit",
              int'(in_ready), 1);
    endtask

    // Output back-pressure, changed on falling edges only
    always @(negedge clk) begin
        bp_lfsr = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
        out_ready = bp_on ? (bp_lfsr[0] | bp_lfsr[3]) : 1'b1;
    end

    // Scoreboard monitor
    initial begin : monitor
        bit held_v;
        bit held_b;
        bit held_l;
        exp_t e;
        held_v = 0;
        held_b = 0;
        held_l = 0;
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                held_v = 0;
            end else begin
                if (held_v) begin
                    check(out_valid === 1'b1 && out_bit === held_b && out_last === held_l,
                          "R7", "output held under back-pressure", int'(out_bit), int'(held_b));
                end
                if (out_valid) begin
                    check(in_ready === 1'b0, "R6", "input closed while sending", int'(in_ready), 0);
                end
                held_v = out_valid && !out_ready;
                held_b = out_bit;
                held_l = out_last;
                if (out_valid && out_ready) begin
                    if (q.size() == 0) begin
                        check(0, "R5", "unexpected codeword bit", 1, 0);
                    end else begin
                        e = q.pop_front();
                        check(out_bit === e.b, region_tag(e.region), "codeword bit",
                              int'(out_bit), int'(e.b));
                        check(out_last === e.last, "R5", "last flag", int'(out_last), int'(e.last));
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [624:0] blk;
        repeat (3) @(negedge clk);
        #1;
        check(in_ready === 1'b1 && out_valid === 1'b0, "R1", "state during reset",
              int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(in_ready === 1'b1 && out_valid === 1'b0, "R1", "state after reset",
              int'(in_ready), 1);

        // R2 R3 R4: fixed patterns, blocks offered back to back (R6)
        send_block('0);
        send_block('1);
        blk = '0; blk[0] = 1'b1;
        send_block(blk);
        blk = '0; blk[624] = 1'b1;
        send_block(blk);
        for (int i = 0; i < 625; i++) blk[i] = ((i / 25) + (i % 25)) % 2;
        send_block(blk);
        wait_drained();

        // R7: random fills under back-pressure
        bp_on = 1;
        for (int n = 0; n < 2; n++) begin
            for (int i = 0; i < 625; i++) blk[i] = next_rand() & 1;
            send_block(blk);
        end
        wait_drained();

        // R8: reset partway through loading, then a fresh block
        for (int i = 0; i < 40; i++) put_bit(1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check(in_ready === 1'b1 && out_valid === 1'b0, "R8", "state after abort reset",
              int'(in_ready), 1);
        for (int i = 0; i < 625; i++) blk[i] = next_rand() & 1;
        send_block(blk);
        wait_drained();
        check(q.size() == 0, "R8", "all expected bits seen", q.size(), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule